// File: doc/BRIEF.md
# Pixel-Count Video Timing Generator

This block produces the sync, enable and pixel-selection signals for one video output. A horizontal counter steps through each line. A second counter runs linearly across the whole frame in pixel clocks. Vertical sync, the vertical display window and the vertical active window are all defined as absolute positions on this frame counter, not as line numbers. A host programs the geometry through a small word-addressed register port. It then sets the run bit, and the block repeats frames until the bit is cleared.

Inside the display window the block forwards pixels from an input stream while the position is in the active window. It paints a fixed border color on display pixels that lie outside the active window. It paints a fixed underflow color when an active pixel is due and the stream has none ready. A separate data-valid strobe can be timed apart from the display window, with an option to halve its length for a double-width data path. Line and frame counters can be read back and cleared by software. Timing words take effect only at a frame boundary.

Top module: `pixel_timing_gen`

## Requirements
- R1: Register map (word address on `regAddr`): 0 run control (bit 0), 1 window control, 2 data-valid control, 3 line word (line period in bits 31:16, hsync width in bits 15:0), 4 frame period in pixel clocks, 5 vsync width in pixel clocks, 6 horizontal display window (last pixel in 31:16, first in 15:0), 7 display vertical first count, 8 display vertical last count, 9 horizontal active window (last 31:16, first 15:0), 10 active vertical first count, 11 active vertical last count, 12 border color, 13 underflow color, 14 polarity, 15 line counter, 16 frame counter. Addresses 0 to 14 read back the last word written to them.
- R2: While bit 0 of address 0 is clear, the counters are held at zero, line and frame counters read 0, and `pixInReady`, `dataValidOut` and `pixOut` are 0. Each sync and enable output sits at its polarity bit, so it reads as inactive.
- R3: The horizontal position counts 0 up to line period − 1 and then wraps. Hsync is asserted while the position is below the hsync width.
- R4: The frame pixel count runs 0 up to frame period − 1 and then wraps, and the horizontal position is cleared at the same time. Vsync is asserted while the frame count is below the vsync width.
- R5: Display enable is asserted when both hold: the horizontal position is within the inclusive horizontal display window, and the frame count is within the inclusive range from address 7 to address 8.
- R6: With bit 29 of address 1 set, active pixels are further limited to the horizontal active window. With bit 30 set, they are limited to the inclusive frame-count range from address 10 to address 11. A cleared bit removes that limit. Active pixels are always display pixels, and `pixInReady` is high exactly on active pixels.
- R7: `pixOut` is 0 outside the display window. It carries the border color on display pixels that are not active. On active pixels it carries `pixIn` when `pixInValid` is high, and the underflow color otherwise.
- R8: With bit 4 of address 2 set, data-valid is high within the vertical display range from the first display pixel of a line for `dw` pixels. `dw` is the display width, or half of it (rounded down) when bit 0 of address 2 is also set. With bit 4 clear, data-valid equals display enable.
- R9: Polarity bits 0, 1 and 2 invert hsync, vsync and display enable respectively. Data-valid is never inverted.
- R10: The line counter (address 15, bits 15:0) increments at each horizontal wrap and returns to 0 at the frame wrap. The frame counter (address 16) increments by one at each frame wrap.
- R11: Writing address 15 with bit 31 set clears the line and frame counters and restarts the frame at pixel count 0 on the next cycle.
- R12: Addresses 1 to 11 written while running take effect only at the next frame wrap, restart or start. Colors and polarity take effect at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| pixInValid | input | 1 | Input stream has a pixel |
| pixIn | input | COLOR_W | Input stream pixel |
| pixInReady | output | 1 | Input pixel consumed this cycle (active pixel) |
| hsyncOut | output | 1 | Horizontal sync after polarity |
| vsyncOut | output | 1 | Vertical sync after polarity |
| deOut | output | 1 | Display enable after polarity |
| dataValidOut | output | 1 | Data-valid strobe |
| pixOut | output | COLOR_W | Output pixel |

## Verification
Several behaviours are checked on every cycle: the wrap of the horizontal and frame counters, the one-step increment of the frame counter, the clearing on a counter restart, the idle levels when stopped, and the rule that the live timing never changes between frame boundaries. The placement of each window, the pixel source selection, the halved data-valid window, the polarity inversion and the deferred effect of a mid-frame write depend on programmed geometry. Only the bench scenarios show these, by sampling chosen frame positions against values worked out from the requirements.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int H_W     = 16;
  localparam int FRAME_W = 24;
  localparam int ADDR_W  = 5;
  localparam int WORD_W  = 32;
  localparam int REG_N   = 2 ** ADDR_W;

  localparam logic [ADDR_W-1:0] A_RUN      = 5'd0;
  localparam logic [ADDR_W-1:0] A_WINCTL   = 5'd1;
  localparam logic [ADDR_W-1:0] A_DVCTL    = 5'd2;
  localparam logic [ADDR_W-1:0] A_LINEWORD = 5'd3;
  localparam logic [ADDR_W-1:0] A_FPERIOD  = 5'd4;
  localparam logic [ADDR_W-1:0] A_VSWIDTH  = 5'd5;
  localparam logic [ADDR_W-1:0] A_DISPH    = 5'd6;
  localparam logic [ADDR_W-1:0] A_DISPVLO  = 5'd7;
  localparam logic [ADDR_W-1:0] A_DISPVHI  = 5'd8;
  localparam logic [ADDR_W-1:0] A_ACTH     = 5'd9;
  localparam logic [ADDR_W-1:0] A_ACTVLO   = 5'd10;
  localparam logic [ADDR_W-1:0] A_ACTVHI   = 5'd11;
  localparam logic [ADDR_W-1:0] A_BORDER   = 5'd12;
  localparam logic [ADDR_W-1:0] A_UNDER    = 5'd13;
  localparam logic [ADDR_W-1:0] A_POLARITY = 5'd14;
  localparam logic [ADDR_W-1:0] A_LINECNT  = 5'd15;
  localparam logic [ADDR_W-1:0] A_FRAMECNT = 5'd16;

  localparam int BIT_ACTH   = 29;
  localparam int BIT_ACTV   = 30;
  localparam int BIT_WIDE   = 0;
  localparam int BIT_DVEN   = 4;
  localparam int BIT_CNTRST = 31;

  // Geometry in force for the current frame
  typedef struct packed {
    logic               actHEn;
    logic               actVEn;
    logic               dvEn;
    logic               wide;
    logic [H_W-1:0]     hPeriod;
    logic [H_W-1:0]     hsWidth;
    logic [H_W-1:0]     dispHFirst;
    logic [H_W-1:0]     dispHLast;
    logic [H_W-1:0]     actHFirst;
    logic [H_W-1:0]     actHLast;
    logic [FRAME_W-1:0] fPeriod;
    logic [FRAME_W-1:0] vsWidth;
    logic [FRAME_W-1:0] dispVFirst;
    logic [FRAME_W-1:0] dispVLast;
    logic [FRAME_W-1:0] actVFirst;
    logic [FRAME_W-1:0] actVLast;
  } timing_t;

  // Strobes from the control to the datapath, before polarity
  typedef struct packed {
    logic hsync;
    logic vsync;
    logic de;
    logic dv;
    logic active;
  } strobe_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int COLOR_W  = 24,
  parameter int FCOUNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  output logic [WORD_W-1:0]   regRdData,
  input  logic                loadNow,
  input  logic [H_W-1:0]      lineCount,
  input  logic [FCOUNT_W-1:0] frameCount,
  output logic                enBit,
  output logic                cntRst,
  output timing_t             liveCfg,
  output logic [COLOR_W-1:0]  borderColor,
  output logic [COLOR_W-1:0]  underColor,
  output logic [2:0]          polarity
);
  logic [WORD_W-1:0] regFile [REG_N];
  timing_t stagedCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_N; i++) regFile[i] <= '0;
    end else if (regWrEn && regAddr <= A_POLARITY) begin
      regFile[regAddr] <= regWrData;
    end
  end

  // Decode the staged words into the geometry record
  always_comb begin
    stagedCfg.actHEn     = regFile[A_WINCTL][BIT_ACTH];
    stagedCfg.actVEn     = regFile[A_WINCTL][BIT_ACTV];
    stagedCfg.dvEn       = regFile[A_DVCTL][BIT_DVEN];
    stagedCfg.wide       = regFile[A_DVCTL][BIT_WIDE];
    stagedCfg.hPeriod    = regFile[A_LINEWORD][31:16];
    stagedCfg.hsWidth    = regFile[A_LINEWORD][15:0];
    stagedCfg.dispHLast  = regFile[A_DISPH][31:16];
    stagedCfg.dispHFirst = regFile[A_DISPH][15:0];
    stagedCfg.actHLast   = regFile[A_ACTH][31:16];
    stagedCfg.actHFirst  = regFile[A_ACTH][15:0];
    stagedCfg.fPeriod    = regFile[A_FPERIOD][FRAME_W-1:0];
    stagedCfg.vsWidth    = regFile[A_VSWIDTH][FRAME_W-1:0];
    stagedCfg.dispVFirst = regFile[A_DISPVLO][FRAME_W-1:0];
    stagedCfg.dispVLast  = regFile[A_DISPVHI][FRAME_W-1:0];
    stagedCfg.actVFirst  = regFile[A_ACTVLO][FRAME_W-1:0];
    stagedCfg.actVLast   = regFile[A_ACTVHI][FRAME_W-1:0];
  end

  // Shadow copy: only moves at a frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        liveCfg <= '0;
    else if (loadNow) liveCfg <= stagedCfg;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr <= A_POLARITY)       regRdData = regFile[regAddr];
    else if (regAddr == A_LINECNT)   regRdData[H_W-1:0] = lineCount;
    else if (regAddr == A_FRAMECNT)  regRdData[FCOUNT_W-1:0] = frameCount;
  end

  assign enBit       = regFile[A_RUN][0];
  assign cntRst      = regWrEn && (regAddr == A_LINECNT) && regWrData[BIT_CNTRST];
  assign borderColor = regFile[A_BORDER][COLOR_W-1:0];
  assign underColor  = regFile[A_UNDER][COLOR_W-1:0];
  assign polarity    = regFile[A_POLARITY][2:0];
endmodule

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int FCOUNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enBit,
  input  logic                cntRst,
  input  timing_t             cfg,
  output logic                running,
  output logic [H_W-1:0]      hCnt,
  output logic [FRAME_W-1:0]  fCnt,
  output logic [H_W-1:0]      lineCount,
  output logic [FCOUNT_W-1:0] frameCount,
  output logic                loadNow,
  output strobe_t             strb
);
  localparam int HW1 = H_W + 1;

  logic lastPix, lastInLine;
  logic inDispH, inDispV, inActH, inActV, inDataH;
  logic [HW1-1:0] dispWidth, dataWidth;

  assign lastPix    = fCnt == cfg.fPeriod - FRAME_W'(1);
  assign lastInLine = hCnt == cfg.hPeriod - H_W'(1);
  assign loadNow    = enBit && (!running || cntRst || lastPix);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      hCnt       <= '0;
      fCnt       <= '0;
      lineCount  <= '0;
      frameCount <= '0;
    end else begin
      running <= enBit;
      if (!enBit || !running || cntRst) begin
        hCnt       <= '0;
        fCnt       <= '0;
        lineCount  <= '0;
        frameCount <= '0;
      end else if (lastPix) begin
        hCnt       <= '0;
        fCnt       <= '0;
        lineCount  <= '0;
        frameCount <= frameCount + FCOUNT_W'(1);
      end else begin
        fCnt <= fCnt + FRAME_W'(1);
        if (lastInLine) begin
          hCnt      <= '0;
          lineCount <= lineCount + H_W'(1);
        end else begin
          hCnt <= hCnt + H_W'(1);
        end
      end
    end
  end

  // Window decode: horizontal on the line position, vertical on the linear count
  assign inDispH = (hCnt >= cfg.dispHFirst) && (hCnt <= cfg.dispHLast);
  assign inDispV = (fCnt >= cfg.dispVFirst) && (fCnt <= cfg.dispVLast);
  assign inActH  = !cfg.actHEn || ((hCnt >= cfg.actHFirst) && (hCnt <= cfg.actHLast));
  assign inActV  = !cfg.actVEn || ((fCnt >= cfg.actVFirst) && (fCnt <= cfg.actVLast));

  assign dispWidth = {1'b0, cfg.dispHLast} - {1'b0, cfg.dispHFirst} + HW1'(1);
  assign dataWidth = cfg.wide ? (dispWidth >> 1) : dispWidth;
  assign inDataH   = (hCnt >= cfg.dispHFirst) &&
                     ({1'b0, hCnt} < {1'b0, cfg.dispHFirst} + dataWidth);

  always_comb begin
    strb.hsync  = running && (hCnt < cfg.hsWidth);
    strb.vsync  = running && (fCnt < cfg.vsWidth);
    strb.de     = running && inDispH && inDispV;
    strb.dv     = running && inDispV && (cfg.dvEn ? inDataH : inDispH);
    strb.active = running && inDispH && inDispV && inActH && inActV;
  end
endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int COLOR_W = 24
) (
  input  strobe_t             strb,
  input  logic [2:0]          polarity,
  input  logic [COLOR_W-1:0]  borderColor,
  input  logic [COLOR_W-1:0]  underColor,
  input  logic                pixInValid,
  input  logic [COLOR_W-1:0]  pixIn,
  output logic                pixInReady,
  output logic                hsyncOut,
  output logic                vsyncOut,
  output logic                deOut,
  output logic                dataValidOut,
  output logic [COLOR_W-1:0]  pixOut
);
  assign hsyncOut     = strb.hsync ^ polarity[0];
  assign vsyncOut     = strb.vsync ^ polarity[1];
  assign deOut        = strb.de    ^ polarity[2];
  assign dataValidOut = strb.dv;
  assign pixInReady   = strb.active;

  always_comb begin
    if (!strb.de)          pixOut = '0;
    else if (!strb.active) pixOut = borderColor;
    else if (pixInValid)   pixOut = pixIn;
    else                   pixOut = underColor;
  end
endmodule

// File: rtl/pixel_timing_gen.sv
module pixel_timing_gen
  import vtg_pkg::*;
#(
  parameter int COLOR_W  = 24,
  parameter int FCOUNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [4:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic               pixInValid,
  input  logic [COLOR_W-1:0] pixIn,
  output logic               pixInReady,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               deOut,
  output logic               dataValidOut,
  output logic [COLOR_W-1:0] pixOut
);
  logic                enBit, cntRst, loadNow, running;
  timing_t             liveCfg;
  strobe_t             strb;
  logic [COLOR_W-1:0]  borderColor, underColor;
  logic [2:0]          polarity;
  logic [H_W-1:0]      hCnt, lineCount;
  logic [FRAME_W-1:0]  fCnt;
  logic [FCOUNT_W-1:0] frameCount;

  vtg_regs #(.COLOR_W(COLOR_W), .FCOUNT_W(FCOUNT_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .loadNow(loadNow),
    .lineCount(lineCount), .frameCount(frameCount), .enBit(enBit),
    .cntRst(cntRst), .liveCfg(liveCfg), .borderColor(borderColor),
    .underColor(underColor), .polarity(polarity)
  );

  vtg_ctrl #(.FCOUNT_W(FCOUNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enBit(enBit), .cntRst(cntRst), .cfg(liveCfg),
    .running(running), .hCnt(hCnt), .fCnt(fCnt), .lineCount(lineCount),
    .frameCount(frameCount), .loadNow(loadNow), .strb(strb)
  );

  vtg_datapath #(.COLOR_W(COLOR_W)) u_dp (
    .strb(strb), .polarity(polarity), .borderColor(borderColor),
    .underColor(underColor), .pixInValid(pixInValid), .pixIn(pixIn),
    .pixInReady(pixInReady), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .deOut(deOut), .dataValidOut(dataValidOut), .pixOut(pixOut)
  );
endmodule

// File: rtl/pixel_timing_gen_checker.sv
module pixel_timing_gen_checker
  import vtg_pkg::*;
#(
  parameter int FCOUNT_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                enBit,
  input logic                cntRst,
  input logic                loadNow,
  input logic                running,
  input timing_t             liveCfg,
  input logic [H_W-1:0]      hCnt,
  input logic [FRAME_W-1:0]  fCnt,
  input logic [H_W-1:0]      lineCount,
  input logic [FCOUNT_W-1:0] frameCount,
  input logic [2:0]          polarity,
  input logic                hsyncOut,
  input logic                vsyncOut,
  input logic                deOut,
  input logic                dataValidOut,
  input logic                pixInReady
);
  logic counting;
  assign counting = running && enBit && !cntRst;

  assert_hwrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (counting && hCnt == liveCfg.hPeriod - H_W'(1)) |=> (hCnt == '0));

  assert_fwrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (counting && fCnt == liveCfg.fPeriod - FRAME_W'(1)) |=>
      (fCnt == '0 && hCnt == '0 && lineCount == '0));

  assert_frame_inc_R10: assert property (@(posedge clk) disable iff (!rstN)
    (counting && fCnt == liveCfg.fPeriod - FRAME_W'(1)) |=>
      (frameCount == FCOUNT_W'($past(frameCount) + FCOUNT_W'(1))));

  assert_restart_R11: assert property (@(posedge clk) disable iff (!rstN)
    (running && enBit && cntRst) |=> (fCnt == '0 && frameCount == '0));

  assert_idle_levels_R2: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (hsyncOut == polarity[0] && vsyncOut == polarity[1] &&
                  deOut == polarity[2] && !dataValidOut && !pixInReady));

  assert_shadow_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (running && !loadNow) |=> $stable(liveCfg));

  assert_ready_in_display_R6: assert property (@(posedge clk) disable iff (!rstN)
    pixInReady |-> (deOut != polarity[2]));
endmodule

bind pixel_timing_gen pixel_timing_gen_checker #(.FCOUNT_W(FCOUNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .enBit(enBit), .cntRst(cntRst), .loadNow(loadNow),
  .running(running), .liveCfg(liveCfg), .hCnt(hCnt), .fCnt(fCnt),
  .lineCount(lineCount), .frameCount(frameCount), .polarity(polarity),
  .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
  .dataValidOut(dataValidOut), .pixInReady(pixInReady)
);

// File: tb/pixel_timing_gen_bench.sv
module pixel_timing_gen_bench;
  localparam int COLOR_W = 24;
  localparam logic [COLOR_W-1:0] BORDER = 24'h112233;
  localparam logic [COLOR_W-1:0] UNDER  = 24'hABCDEF;
  localparam logic [COLOR_W-1:0] PIXVAL = 24'h5A5A5A;

  // {pos[7:0], pixInValid, hs, vs, de, dv, ready, sel[1:0]}
  // sel: 0 zero, 1 border, 2 input pixel, 3 underflow color
  // Geometry: line 10, hsync 2, frame 60, vsync 10, display h 3..8,
  // display v 20..49, active h 4..7, active v 30..39
  localparam int NVEC = 14;
  localparam logic [15:0] VEC [NVEC] = '{
    {8'd0,  1'b0, 5'b11000, 2'd0},
    {8'd5,  1'b0, 5'b01000, 2'd0},
    {8'd11, 1'b0, 5'b10000, 2'd0},
    {8'd23, 1'b1, 5'b00110, 2'd1},
    {8'd34, 1'b1, 5'b00111, 2'd2},
    {8'd35, 1'b0, 5'b00111, 2'd3},
    {8'd38, 1'b1, 5'b00110, 2'd1},
    {8'd39, 1'b1, 5'b00000, 2'd0},
    {8'd47, 1'b1, 5'b00110, 2'd1},
    {8'd49, 1'b0, 5'b00000, 2'd0},
    {8'd48, 1'b0, 5'b00110, 2'd1},
    {8'd52, 1'b0, 5'b00000, 2'd0},
    {8'd30, 1'b1, 5'b10000, 2'd0},
    {8'd37, 1'b1, 5'b00111, 2'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic pixInValid = 1'b0;
  logic [COLOR_W-1:0] pixIn = PIXVAL;
  logic pixInReady, hsyncOut, vsyncOut, deOut, dataValidOut;
  logic [COLOR_W-1:0] pixOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pixel_timing_gen #(.COLOR_W(COLOR_W)) u_pixel_timing_gen (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pixInValid(pixInValid),
    .pixIn(pixIn), .pixInReady(pixInReady), .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut), .deOut(deOut), .dataValidOut(dataValidOut),
    .pixOut(pixOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic restart();
    wr(5'd15, 32'h8000_0000);
  endtask

  function automatic logic [COLOR_W-1:0] selColor(input logic [1:0] s);
    case (s)
      2'd1:    return BORDER;
      2'd2:    return PIXVAL;
      2'd3:    return UNDER;
      default: return '0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state: stopped, polarity 0
    rd(5'd3, r);  chk("R1 reset line word", r, 32'h0);
    rd(5'd16, r); chk("R2 reset frame count", r, 32'h0);
    chk("R2 reset hsync", {31'b0, hsyncOut}, 32'h0);
    chk("R2 reset de", {31'b0, deOut}, 32'h0);
    chk("R2 reset ready", {31'b0, pixInReady}, 32'h0);
    chk("R2 reset pixel", {8'b0, pixOut}, 32'h0);

    wr(5'd1,  32'h6000_0000);
    wr(5'd2,  32'h0000_0010);
    wr(5'd3,  32'h000A_0002);
    wr(5'd4,  32'd60);
    wr(5'd5,  32'd10);
    wr(5'd6,  32'h0008_0003);
    wr(5'd7,  32'd20);
    wr(5'd8,  32'd49);
    wr(5'd9,  32'h0007_0004);
    wr(5'd10, 32'd30);
    wr(5'd11, 32'd39);
    wr(5'd12, {8'b0, BORDER});
    wr(5'd13, {8'b0, UNDER});
    wr(5'd14, 32'h0);
    rd(5'd3, r);  chk("R1 readback line word", r, 32'h000A_0002);
    rd(5'd12, r); chk("R1 readback border", r, {8'b0, BORDER});
    wr(5'd0, 32'h1);

    // Table walk over frame positions
    for (int i = 0; i < NVEC; i++) begin
      restart();
      repeat (int'(VEC[i][15:8])) @(negedge clk);
      pixInValid = VEC[i][7];
      #1;
      chk($sformatf("R3 hsync pos %0d", VEC[i][15:8]), {31'b0, hsyncOut}, {31'b0, VEC[i][6]});
      chk($sformatf("R4 vsync pos %0d", VEC[i][15:8]), {31'b0, vsyncOut}, {31'b0, VEC[i][5]});
      chk($sformatf("R5 de pos %0d", VEC[i][15:8]), {31'b0, deOut}, {31'b0, VEC[i][4]});
      chk($sformatf("R8 dv pos %0d", VEC[i][15:8]), {31'b0, dataValidOut}, {31'b0, VEC[i][3]});
      chk($sformatf("R6 ready pos %0d", VEC[i][15:8]), {31'b0, pixInReady}, {31'b0, VEC[i][2]});
      chk($sformatf("R7 pixel pos %0d", VEC[i][15:8]), {8'b0, pixOut}, {8'b0, selColor(VEC[i][1:0])});
      pixInValid = 1'b0;
    end

    // R8 halved data-valid window: width 6 -> 3 (h 3..5)
    wr(5'd2, 32'h0000_0011);
    restart();
    repeat (25) @(negedge clk);
    #1; chk("R8 half window last", {31'b0, dataValidOut}, 32'h1);
    @(negedge clk); #1;
    chk("R8 half window past end", {31'b0, dataValidOut}, 32'h0);
    chk("R5 de beyond half window", {31'b0, deOut}, 32'h1);
    // R8 data-valid follows display enable when bit 4 clear
    wr(5'd2, 32'h0);
    restart();
    repeat (26) @(negedge clk);
    #1; chk("R8 dv equals de", {31'b0, dataValidOut}, 32'h1);
    wr(5'd2, 32'h0000_0010);

    // R6 active gating off: whole display window is active
    wr(5'd1, 32'h0);
    restart();
    repeat (23) @(negedge clk);
    pixInValid = 1'b1; #1;
    chk("R6 ungated ready", {31'b0, pixInReady}, 32'h1);
    chk("R7 ungated pixel", {8'b0, pixOut}, {8'b0, PIXVAL});
    pixInValid = 1'b0;
    wr(5'd1, 32'h6000_0000);

    // R9 polarity inversion at pos 0
    wr(5'd14, 32'h7);
    restart(); #1;
    chk("R9 hsync inverted", {31'b0, hsyncOut}, 32'h0);
    chk("R9 vsync inverted", {31'b0, vsyncOut}, 32'h0);
    chk("R9 de inverted", {31'b0, deOut}, 32'h1);
    chk("R9 dv not inverted", {31'b0, dataValidOut}, 32'h0);
    wr(5'd14, 32'h0);

    // R10 line and frame counters
    restart();
    repeat (25) @(negedge clk);
    rd(5'd15, r); chk("R10 line count", r, 32'd2);
    rd(5'd16, r); chk("R10 frame count before wrap", r, 32'd0);
    repeat (35) @(negedge clk);
    rd(5'd16, r); chk("R10 frame count after wrap", r, 32'd1);
    rd(5'd15, r); chk("R10 line count after wrap", r, 32'd0);

    // R11 counter clear
    repeat (13) @(negedge clk);
    restart();
    rd(5'd16, r); chk("R11 frame count cleared", r, 32'd0);
    rd(5'd15, r); chk("R11 line count cleared", r, 32'd0);

    // R12 mid-frame write deferred to next frame
    restart();
    repeat (11) @(negedge clk);
    wr(5'd3, 32'h000A_0004);
    #1; chk("R12 old hsync width in frame", {31'b0, hsyncOut}, 32'h0);
    repeat (60) @(negedge clk);
    #1; chk("R12 new hsync width next frame", {31'b0, hsyncOut}, 32'h1);
    wr(5'd3, 32'h000A_0002);

    // R2 stop: idle levels follow polarity
    wr(5'd14, 32'h5);
    wr(5'd0, 32'h0);
    @(negedge clk);
    pixInValid = 1'b1; #1;
    chk("R2 stopped hsync level", {31'b0, hsyncOut}, 32'h1);
    chk("R2 stopped vsync level", {31'b0, vsyncOut}, 32'h0);
    chk("R2 stopped de level", {31'b0, deOut}, 32'h1);
    chk("R2 stopped dv", {31'b0, dataValidOut}, 32'h0);
    chk("R2 stopped ready", {31'b0, pixInReady}, 32'h0);
    chk("R2 stopped pixel", {8'b0, pixOut}, 32'h0);
    rd(5'd15, r); chk("R2 stopped line count", r, 32'h0);
    rd(5'd16, r); chk("R2 stopped frame count", r, 32'h0);
    pixInValid = 1'b0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule